// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A 16-state sequencer is clocked by the test clock and steered by the mode-select input. The port holds a 4-bit instruction register, a one-bit bypass stage and a 32-bit identification register. It routes whichever register the current instruction addresses onto the serial output. The port also decodes four instructions: external test, sample/preload, bypass and identification. For the first two it drives capture, shift and update strobes toward a boundary-scan chain that sits outside the block.

The serial output changes on the falling test-clock edge and is qualified by an output-enable. This enable is high only while a register is being shifted. An active-low asynchronous reset returns the sequencer to its reset state at once. Holding mode-select high for five rising edges reaches the same state from anywhere.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: `tap_state` follows the standard 16-state test port graph on each rising `tck`, choosing the successor from `tms`. The encoding is: 0 reset, 1 idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR.
- R2: Driving `trst_n` low puts `tap_state` at 0 and `tdo_oe` at 0 without a clock edge. It also makes identification the current instruction.
- R3: Five consecutive rising edges with `tms` high bring `tap_state` to 0 from each of the 16 states.
- R4: Every rising edge spent in state 0 makes identification the current instruction.
- R5: Capture-IR loads 4'b0001 into the instruction shift stage. Shift-IR moves it out least significant bit first, with `tdi` entering at the top bit.
- R6: Update-IR makes the shifted code current. 4'b0000 is external test, 4'b0001 is identification, 4'b0010 is sample/preload and 4'b1111 is bypass. Any other code acts as bypass.
- R7: Under identification, capture-DR loads {version[3:0], part[15:0], maker[10:0], 1'b1}. Shift-DR outputs it least significant bit first.
- R8: Under bypass, capture-DR loads 0. While shifting, `tdo` repeats `tdi` one clock later.
- R9: Under external test or sample/preload, `tdo` in shift-DR follows `bsr_tdo`. Also, `bs_capture`, `bs_shift` and `bs_update` are high in capture-DR, shift-DR and update-DR respectively. Under any other instruction they stay low. `extest_mode` is high only under external test.
- R10: `tdo` and `tdo_oe` change on falling `tck`. `tdo_oe` is high exactly when the state is shift-IR or shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid when tdo_oe is high |
| tdo_oe | output | 1 | Output-enable for tdo |
| bsr_tdo | input | 1 | Serial output of the external boundary chain |
| bs_capture | output | 1 | Boundary chain parallel capture strobe |
| bs_shift | output | 1 | Boundary chain shift enable |
| bs_update | output | 1 | Boundary chain update strobe |
| extest_mode | output | 1 | Boundary chain drives the pins |
| tap_state | output | 4 | Current sequencer state |

## Verification
The assertions check several properties on every clock:
- the hold of shift-DR under a low `tms`;
- the captured instruction pattern;
- that the current instruction only changes in update-IR or reset;
- that the boundary strobes are mutually exclusive;
- that the output-enable agrees with the shift states.

Other behaviour is shown only by the bench's scenarios. This covers coverage of all 32 graph edges, the five-edge recovery from each state, and the exact serial order of the identification word. It also covers the one-clock bypass delay, fallback of undefined codes to bypass, and instruction restoration after an asynchronous reset in mid-shift.

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl #(
  parameter int              IR_W       = 4,
  parameter logic [3:0]      ID_VERSION = 4'h3,
  parameter logic [15:0]     ID_PART    = 16'h6a5c,
  parameter logic [10:0]     ID_MAKER   = 11'h0cf,
  parameter logic [IR_W-1:0] OP_EXTEST  = '0,
  parameter logic [IR_W-1:0] OP_IDCODE  = IR_W'(1),
  parameter logic [IR_W-1:0] OP_SAMPLE  = IR_W'(2),
  parameter logic [IR_W-1:0] OP_BYPASS  = '1
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdo,
  output logic       tdo_oe,
  input  logic       bsr_tdo,
  output logic       bs_capture,
  output logic       bs_shift,
  output logic       bs_update,
  output logic       extest_mode,
  output logic [3:0] tap_state
);
  localparam int         ID_W    = 32;
  localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};
  localparam logic [IR_W-1:0] IR_CAP  = {{(IR_W-2){1'b0}}, 2'b01};

  typedef enum logic [3:0] {
    S_RESET = 4'd0,  S_IDLE  = 4'd1,  S_SELDR = 4'd2,  S_CAPDR = 4'd3,
    S_SHDR  = 4'd4,  S_X1DR  = 4'd5,  S_PSDR  = 4'd6,  S_X2DR  = 4'd7,
    S_UPDR  = 4'd8,  S_SELIR = 4'd9,  S_CAPIR = 4'd10, S_SHIR  = 4'd11,
    S_X1IR  = 4'd12, S_PSIR  = 4'd13, S_X2IR  = 4'd14, S_UPIR  = 4'd15
  } st_t;

  st_t st, st_nx;
  logic [IR_W-1:0] ir_sh, ir;
  logic [ID_W-1:0] id_sh;
  logic            byp, tdo_r;
  logic            sel_id, sel_bsr;

  always_comb begin
    case (st)
      S_RESET: st_nx = tms ? S_RESET : S_IDLE;
      S_IDLE:  st_nx = tms ? S_SELDR : S_IDLE;
      S_SELDR: st_nx = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: st_nx = tms ? S_X1DR  : S_SHDR;
      S_SHDR:  st_nx = tms ? S_X1DR  : S_SHDR;
      S_X1DR:  st_nx = tms ? S_UPDR  : S_PSDR;
      S_PSDR:  st_nx = tms ? S_X2DR  : S_PSDR;
      S_X2DR:  st_nx = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  st_nx = tms ? S_SELDR : S_IDLE;
      S_SELIR: st_nx = tms ? S_RESET : S_CAPIR;
      S_CAPIR: st_nx = tms ? S_X1IR  : S_SHIR;
      S_SHIR:  st_nx = tms ? S_X1IR  : S_SHIR;
      S_X1IR:  st_nx = tms ? S_UPIR  : S_PSIR;
      S_PSIR:  st_nx = tms ? S_X2IR  : S_PSIR;
      S_X2IR:  st_nx = tms ? S_UPIR  : S_SHIR;
      S_UPIR:  st_nx = tms ? S_SELDR : S_IDLE;
      default: st_nx = S_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st <= S_RESET;
    else         st <= st_nx;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      ir_sh <= '0;
      ir    <= OP_IDCODE;
    end else begin
      if (st == S_CAPIR)     ir_sh <= IR_CAP;
      else if (st == S_SHIR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      if (st == S_RESET)     ir <= OP_IDCODE;
      else if (st == S_UPIR) ir <= ir_sh;
    end

  assign sel_id  = (ir == OP_IDCODE);
  assign sel_bsr = (ir == OP_EXTEST) || (ir == OP_SAMPLE);

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      byp   <= 1'b0;
      id_sh <= '0;
    end else if (st == S_CAPDR) begin
      byp   <= 1'b0;
      id_sh <= ID_WORD;
    end else if (st == S_SHDR) begin
      byp   <= tdi;
      id_sh <= {tdi, id_sh[ID_W-1:1]};
    end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo_r  <= 1'b1;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st == S_SHIR) || (st == S_SHDR);
      tdo_r  <= (st == S_SHIR) ? ir_sh[0] :
                sel_id         ? id_sh[0] :
                sel_bsr        ? bsr_tdo  : byp;
    end

  assign tdo         = tdo_r;
  assign tap_state   = st;
  assign bs_capture  = sel_bsr && (st == S_CAPDR);
  assign bs_shift    = sel_bsr && (st == S_SHDR);
  assign bs_update   = sel_bsr && (st == S_UPDR);
  assign extest_mode = (ir == OP_EXTEST);

  p_shdr_hold_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_SHDR && !tms) |=> (st == S_SHDR));
  p_reset_idcode_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_RESET) |=> (ir == OP_IDCODE));
  p_capir_pattern_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_CAPIR) |=> (ir_sh == IR_CAP));
  p_ir_stable_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (st != S_UPIR && st != S_RESET) |=> $stable(ir));
  p_strobe_excl_r9: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bs_capture, bs_shift, bs_update}));
  p_oe_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == ((st == S_SHDR) || (st == S_SHIR)));
endmodule

// File: tb/jtag_tap_ctrl_tb.sv
module jtag_tap_ctrl_tb;
  localparam logic [31:0] ID_EXP = {4'h3, 16'h6a5c, 11'h0cf, 1'b1};

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_tdo = 1'b0;
  logic tdo, tdo_oe, bs_capture, bs_shift, bs_update, extest_mode;
  logic [3:0] tap_state;
  int n_run = 0, n_fail = 0, ms = 0, seed = 7;
  bit cov [16][2];
  bit done = 0;

  always #4 tck = ~tck;

  jtag_tap_ctrl #(.ID_VERSION(4'h3), .ID_PART(16'h6a5c), .ID_MAKER(11'h0cf)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsr_tdo(bsr_tdo), .bs_capture(bs_capture), .bs_shift(bs_shift),
    .bs_update(bs_update), .extest_mode(extest_mode), .tap_state(tap_state));

  function automatic int nxt(int s, bit m);
    case (s)
      0: return m ? 0 : 1;    1: return m ? 2 : 1;
      2: return m ? 9 : 3;    3: return m ? 5 : 4;
      4: return m ? 5 : 4;    5: return m ? 8 : 6;
      6: return m ? 7 : 6;    7: return m ? 8 : 4;
      8: return m ? 2 : 1;    9: return m ? 0 : 10;
      10: return m ? 12 : 11; 11: return m ? 12 : 11;
      12: return m ? 15 : 13; 13: return m ? 14 : 13;
      14: return m ? 15 : 11; default: return m ? 2 : 1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input bit m, input bit d);
    tms = m; tdi = d;
    @(posedge tck);
    cov[ms][m] = 1'b1;
    ms = nxt(ms, m);
    @(negedge tck); #1;
  endtask

  task automatic shift_ir(input logic [3:0] code, output logic [3:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      tick(i == 3, code[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shift_dr(input logic [31:0] din, input int n, output logic [31:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_400_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      finish_up();
    end
  end

  initial begin
    logic [3:0] cap;
    logic [31:0] dout, din;
    int steps;
    void'($urandom(seed));
    #21;
    chk("R2 reset state", tap_state, 0);
    chk("R2 reset oe", tdo_oe, 0);
    @(negedge tck); #1; trst_n = 1'b1; ms = 0;

    // R7 and R10: identification read after reset
    tick(0, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R10 oe in shift-DR", tdo_oe, 1);
    for (int i = 0; i < 32; i++) begin
      dout[i] = tdo;
      tick(i == 31, 0);
    end
    chk("R10 oe after shift", tdo_oe, 0);
    chk("R7 id word", dout, ID_EXP);
    tick(1, 0); tick(0, 0);

    // R5: captured instruction pattern; R6 bypass
    shift_ir(4'hF, cap);
    chk("R5 capture-IR", cap, 4'b0001);
    din = $urandom;
    shift_dr(din, 16, dout);
    chk("R8 bypass delay", dout[15:0], {din[14:0], 1'b0});
    for (int k = 0; k < 6; k++) begin
      logic [3:0] c;
      c = 4'($urandom_range(3, 14));
      shift_ir(c, cap);
      din = $urandom;
      shift_dr(din, 12, dout);
      chk("R6 undefined code acts as bypass", dout[11:0], {din[10:0], 1'b0});
    end

    // R9: external test strobes and chain routing
    shift_ir(4'h0, cap);
    chk("R9 extest_mode", extest_mode, 1);
    tick(1, 0);
    chk("R9 no strobe in select", {bs_capture, bs_shift, bs_update}, 0);
    tick(0, 0);
    chk("R9 capture strobe", {bs_capture, bs_shift, bs_update}, 3'b100);
    tick(0, 0);
    chk("R9 shift strobe", {bs_capture, bs_shift, bs_update}, 3'b010);
    for (int k = 0; k < 8; k++) begin
      logic b;
      b = 1'($urandom);
      bsr_tdo = b;
      tick(0, 0);
      chk("R9 tdo follows chain", tdo, b);
    end
    tick(1, 0); tick(1, 0);
    chk("R9 update strobe", {bs_capture, bs_shift, bs_update}, 3'b001);
    tick(0, 0);

    shift_ir(4'h2, cap);
    chk("R9 sample not extest", extest_mode, 0);
    tick(1, 0); tick(0, 0);
    chk("R9 sample capture strobe", bs_capture, 1);
    tick(1, 0); tick(1, 0); tick(0, 0);

    shift_ir(4'h1, cap);
    tick(1, 0); tick(0, 0);
    chk("R9 no strobe under id", bs_capture, 0);
    tick(1, 0); tick(1, 0); tick(0, 0);

    // R2: asynchronous reset in mid-shift restores identification
    shift_ir(4'hF, cap);
    tick(1, 0); tick(0, 0); tick(0, 0);
    #2 trst_n = 1'b0;
    #1;
    chk("R2 async state", tap_state, 0);
    chk("R2 async oe", tdo_oe, 0);
    @(negedge tck); #1; trst_n = 1'b1; ms = 0;
    tick(0, 0);
    shift_dr(32'h0, 32, dout);
    chk("R2 id restored", dout, ID_EXP);

    // R4: synchronous pass through reset restores identification
    shift_ir(4'hF, cap);
    tick(1, 0); tick(1, 0); tick(1, 0); tick(0, 0);
    shift_dr(32'h0, 32, dout);
    chk("R4 id after reset state", dout, ID_EXP);

    // R1 and R10: random walk against the graph model
    for (int k = 0; k < 4000; k++) begin
      tick(1'($urandom), 1'($urandom));
      chk("R1 state", tap_state, ms);
      chk("R10 oe", tdo_oe, (ms == 4 || ms == 11));
    end
    steps = 0;
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 2; m++) steps += cov[s][m];
    chk("R1 all 32 edges walked", steps, 32);

    // R3: five high tms from every state
    for (int t = 0; t < 16; t++) begin
      steps = 0;
      while (ms != t && steps < 2000) begin
        tick(1'($urandom), 1'($urandom));
        steps++;
      end
      chk("R3 reached start state", ms, t);
      for (int j = 0; j < 5; j++) tick(1, 0);
      chk("R3 five-edge reset", tap_state, 0);
    end

    done = 1;
    finish_up();
  end
endmodule